// File: doc/BRIEF.md
# Hysteretic Digital Lock Detector

This block decides whether a phase-locked loop has settled. The loop's phase-frequency detector compares two divider outputs once per comparison cycle: the reference-divider pulse and the feedback-divider pulse. The block catches the rising edge of each pulse in a fast sampling clock domain. It counts the sampling cycles from whichever edge comes first to the other edge and takes that count as the phase error of the cycle. The error has no sign.

The lock flag is active high. It goes high after a run of consecutive comparison cycles whose error is below a tight threshold. Once high, it falls only when a single cycle shows an error at or above a wider threshold. The gap between the two thresholds provides hysteresis, so a loop near the edge does not toggle the flag. When the second edge is overdue, the block does not wait for it. It scores the cycle as a large error at once and then discards the late edge when it arrives. Every scored error is also presented on an output together with a one-cycle valid strobe.

Defaults assume a 400 MHz sampling clock. The tight threshold is 6 counts (15 ns), the wide threshold is 10 counts (25 ns), and the run length is 5 cycles. All three are parameters.

Top module: `phase_lock_monitor`

## Requirements
- R1: While reset is asserted and after it is released, `locked` is 0, `err_valid` is 0 and `err_count` is 0. This holds until the first scored cycle.
- R2: Suppose the reference rising edge is seen at sampling cycle t and the feedback rising edge at cycle t+d, with 1 ≤ d ≤ UNLOCK_TH. In the clock after cycle t+d, `err_valid` is 1 for exactly one cycle and `err_count` equals d.
- R3: If the feedback edge leads the reference edge by d cycles, the result is the same as in R2. The error carries no sign.
- R4: Rising edges on both inputs in the same sampling cycle score an error of 0.
- R5: While unlocked, `locked` rises in the same clock that reports the GOOD_RUN-th consecutive error below LOCK_TH (default 5 errors below 6). It does not rise any earlier.
- R6: While unlocked, an error of LOCK_TH or more clears the consecutive-good count. After it, a full new run of GOOD_RUN good errors is needed.
- R7: While locked, errors below UNLOCK_TH keep `locked` at 1. This includes errors between LOCK_TH and UNLOCK_TH-1.
- R8: While locked, a single error of UNLOCK_TH or more clears `locked` in the same clock that reports that error.
- R9: If the second edge has not come UNLOCK_TH cycles after the first, the cycle is scored as an error of UNLOCK_TH. The late edge is then discarded, and the next comparison starts on the following fresh edge.
- R10: An input held high for several sampling cycles counts as one edge. Only the low-to-high transition starts or ends a measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_pulse | input | 1 | Reference-divider output, synchronous to clk |
| fb_pulse | input | 1 | Feedback-divider output, synchronous to clk |
| locked | output | 1 | Lock flag, active high |
| err_valid | output | 1 | One-cycle strobe: a new error is on err_count |
| err_count | output | $clog2(UNLOCK_TH+1) | Latest scored phase error in sampling cycles, saturated at UNLOCK_TH |

## Verification
The assertions assume that the two pulse inputs alternate as pairs. Each reference edge has exactly one matching feedback edge, and no edge of the same kind repeats before its partner or before a discarded late partner. The stimulus keeps to this assumption by sending every pair inside a fixed 30-cycle frame. Each frame returns both inputs low before its end, and the lag within a frame never exceeds 12 cycles. Under this assumption, each measurement closes before the next frame opens, so the relation between err_valid, err_count and locked edges is unambiguous.

// File: rtl/phase_lock_monitor.sv
module phase_lock_monitor #(
  parameter int LOCK_TH   = 6,
  parameter int UNLOCK_TH = 10,
  parameter int GOOD_RUN  = 5,
  localparam int CW = $clog2(UNLOCK_TH + 1),
  localparam int RW = $clog2(GOOD_RUN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_pulse,
  input  logic          fb_pulse,
  output logic          locked,
  output logic          err_valid,
  output logic [CW-1:0] err_count
);

  localparam logic [CW-1:0] LT_C  = CW'(LOCK_TH);
  localparam logic [CW-1:0] UT_C  = CW'(UNLOCK_TH);
  localparam logic [RW-1:0] RUN_L = RW'(GOOD_RUN - 1);

  typedef enum logic [2:0] {S_IDLE, S_REF_LEAD, S_FB_LEAD, S_SKIP_REF, S_SKIP_FB} st_t;

  st_t st, st_nx;
  logic ref_q, fb_q;
  logic [CW-1:0] cnt, cnt_nx, sval;
  logic [RW-1:0] run;
  logic score, other;

  wire ref_rise = ref_pulse & ~ref_q;
  wire fb_rise  = fb_pulse & ~fb_q;

  always_comb begin
    st_nx  = st;
    cnt_nx = cnt;
    score  = 1'b0;
    sval   = '0;
    other  = (st == S_REF_LEAD) ? fb_rise : ref_rise;
    case (st)
      S_IDLE: begin
        if (ref_rise && fb_rise) begin
          score = 1'b1;
        end else if (ref_rise) begin
          st_nx  = S_REF_LEAD;
          cnt_nx = CW'(1);
        end else if (fb_rise) begin
          st_nx  = S_FB_LEAD;
          cnt_nx = CW'(1);
        end
      end
      S_REF_LEAD, S_FB_LEAD: begin
        if (other) begin
          score = 1'b1;
          sval  = cnt;
          st_nx = S_IDLE;
        end else if (cnt == UT_C) begin
          score = 1'b1;
          sval  = UT_C;
          st_nx = (st == S_REF_LEAD) ? S_SKIP_FB : S_SKIP_REF;
        end else begin
          cnt_nx = cnt + CW'(1);
        end
      end
      S_SKIP_REF: if (ref_rise) st_nx = S_IDLE;
      S_SKIP_FB:  if (fb_rise)  st_nx = S_IDLE;
      default:    st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q <= 1'b0;
      fb_q  <= 1'b0;
      st    <= S_IDLE;
      cnt   <= '0;
    end else begin
      ref_q <= ref_pulse;
      fb_q  <= fb_pulse;
      st    <= st_nx;
      cnt   <= cnt_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked    <= 1'b0;
      run       <= '0;
      err_valid <= 1'b0;
      err_count <= '0;
    end else begin
      err_valid <= score;
      if (score) begin
        err_count <= sval;
        if (!locked) begin
          if (sval < LT_C) begin
            if (run == RUN_L) begin
              locked <= 1'b1;
              run    <= '0;
            end else begin
              run <= run + RW'(1);
            end
          end else begin
            run <= '0;
          end
        end else if (sval >= UT_C) begin
          locked <= 1'b0;
          run    <= '0;
        end
      end
    end
  end

  // R1: nothing is reported before a score
  a_r1_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && !ref_rise && !fb_rise) |=> !err_valid);

  a_r4_coincident: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && ref_rise && fb_rise) |=> (err_valid && err_count == '0));

  a_r5_rise_on_good: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> (err_valid && err_count < LT_C));

  a_r5_run_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run <= RUN_L);

  a_r6_run_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && err_valid && err_count >= LT_C) |-> run == '0);

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(locked) && err_valid && err_count < UT_C) |-> locked);

  a_r8_drop_on_big: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> (err_valid && err_count >= UT_C));

  a_r9_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |-> err_count <= UT_C);

endmodule

// File: tb/test_phase_lock_monitor.sv
`timescale 1ns/100ps
module test_phase_lock_monitor;
  localparam int LT = 6, UT = 10, RUN = 5, FRAME = 30;

  logic clk = 0, rst_n = 0, ref_pulse = 0, fb_pulse = 0;
  logic locked, err_valid;
  logic [3:0] err_count;
  int total = 0, bad = 0;
  string phase = "R1";

  phase_lock_monitor i_phase_lock_monitor (
    .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse), .fb_pulse(fb_pulse),
    .locked(locked), .err_valid(err_valid), .err_count(err_count));

  always #2.5 clk = ~clk;

  // behavioural model: timestamps of the pending edge
  int now = 0, t0 = 0, mode = 0, good = 0, ev = 0;
  bit lk = 0, vv = 0, pr = 0, pf = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void model_score(input int e);
    vv = 1;
    ev = e;
    if (!lk) begin
      if (e < LT) begin
        good++;
        if (good == RUN) begin lk = 1; good = 0; end
      end else good = 0;
    end else if (e >= UT) begin
      lk = 0;
      good = 0;
    end
  endfunction

  always @(posedge clk) begin
    bit rr, fr, oth;
    if (!rst_n) begin
      mode = 0; good = 0; ev = 0; lk = 0; vv = 0; pr = 0; pf = 0;
    end else begin
      rr = ref_pulse && !pr;
      fr = fb_pulse && !pf;
      pr = ref_pulse;
      pf = fb_pulse;
      vv = 0;
      if (mode == 0) begin
        if (rr && fr) model_score(0);
        else if (rr) begin mode = 1; t0 = now; end
        else if (fr) begin mode = 2; t0 = now; end
      end else if (mode == 1 || mode == 2) begin
        oth = (mode == 1) ? fr : rr;
        if (oth) begin model_score(now - t0); mode = 0; end
        else if (now - t0 == UT) begin model_score(UT); mode = (mode == 1) ? 4 : 3; end
      end else if (mode == 3) begin
        if (rr) mode = 0;
      end else if (fr) mode = 0;
    end
    now++;
    #1;
    check(locked == lk, {phase, " locked"}, int'(locked), int'(lk));
    check(err_valid == vv, {phase, " err_valid"}, int'(err_valid), int'(vv));
    check(int'(err_count) == ev, {phase, " err_count"}, int'(err_count), ev);
  end

  // d >= 0: reference leads by d; d < 0: feedback leads by -d
  task automatic send(input int d, input int w);
    int rs = (d < 0) ? -d : 0;
    int fs = (d < 0) ? 0 : d;
    for (int c = 0; c < FRAME; c++) begin
      @(negedge clk);
      ref_pulse = (c >= rs && c < rs + w);
      fb_pulse  = (c >= fs && c < fs + w);
    end
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!locked && !err_valid && err_count == 0, "R1 reset outputs", int'(locked), 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check(!locked && !err_valid && err_count == 0, "R1 after release", int'(err_count), 0);
    phase = "R2"; send(3, 1); check(err_count == 3, "R2 ref lead 3", int'(err_count), 3);
    send(8, 1);   check(err_count == 8, "R2 ref lead 8", int'(err_count), 8);
    phase = "R3"; send(-4, 1); check(err_count == 4, "R3 fb lead 4", int'(err_count), 4);
    send(-9, 1);  check(err_count == 9, "R3 fb lead 9", int'(err_count), 9);
    phase = "R4"; send(0, 1); check(err_count == 0, "R4 coincident", int'(err_count), 0);
    phase = "R6";
    repeat (3) send(2, 1);
    send(6, 1);   check(!locked, "R6 run broken by 6", int'(locked), 0);
    phase = "R5";
    repeat (4) send(1, 1);
    check(!locked, "R5 four good not enough", int'(locked), 0);
    send(-5, 1);  check(locked, "R5 fifth good locks", int'(locked), 1);
    phase = "R7";
    send(9, 1); send(-7, 1);
    check(locked, "R7 errors below 10 hold lock", int'(locked), 1);
    phase = "R8"; send(10, 1); check(!locked, "R8 error 10 unlocks", int'(locked), 0);
    phase = "R10";
    repeat (5) send(2, 3);
    check(locked && err_count == 2, "R10 wide pulses count once", int'(err_count), 2);
    phase = "R9";
    send(12, 1);
    check(!locked && err_count == UT, "R9 timeout scored as 10", int'(err_count), UT);
    send(1, 1);   check(err_count == 1, "R9 late edge discarded", int'(err_count), 1);
    send(-12, 1); check(err_count == UT, "R9 fb-first timeout", int'(err_count), UT);
    send(-3, 1);  check(err_count == 3, "R9 resync after fb timeout", int'(err_count), 3);
    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule